// File: doc/BRIEF.md
# Staggered Three-Leg Output Switch Controller

This block regulates one output of a switched-capacitor converter by commanding three parallel output-switch legs. The legs have strengths in the ratio 1:2:5. A one-bit comparator flag reports whether the divided output sits below its reference. On each rising edge of the charging-phase input, the smallest leg switches on if charge is needed. The middle and largest legs then join at two programmable tick offsets inside the same phase, each only while the output is still low. In this way the effective switch resistance shrinks as the load grows.

As soon as the synchronized comparator shows that the output has crossed above the reference, every leg opens. A hold state then keeps all legs open until the next charging phase begins, so comparator chatter cannot cause a second burst. A phase that starts with the output already above the reference is skipped entirely. The controller stays idle after reset until the startup flag has gone from high to low. All gate commands are registered and are low whenever the charging phase is inactive.

Top module: `seq_leg_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge at which it is sampled high, `gate_o` is 3'b000.
- R2: After reset, `gate_o` stays 3'b000 until `start_hold` has been sampled high and then low. A reset in mid-operation requires this high-to-low transition again.
- R3: `cmp_below_async` = 1 means the output is below the reference. It passes through two synchronizing flops. `gate_o[0]` (weight 1) rises only at the clock edge at which `phase_chg` is first sampled high, and only if the synchronized flag is 1 there.
- R4: `gate_o[1]` (weight 2) rises at the edge that is `tap_mid` cycles after the phase-start edge, and `gate_o[2]` (weight 5) rises `tap_late` cycles after it. Each does so only if the synchronized flag is still 1 and the next smaller leg is on. The offsets satisfy 1 <= `tap_mid` < `tap_late` < phase length.
- R5: Legs are added in fixed order: `gate_o[2]` implies `gate_o[1]`, and `gate_o[1]` implies `gate_o[0]`.
- R6: When `cmp_below_async` falls from 1 to 0 inside a phase, all gates go low on the third clock edge after the change.
- R7: After that crossing, `gate_o` stays 3'b000 for the rest of the phase, whatever the comparator does.
- R8: If the synchronized flag is 0 at the phase-start edge, no gate rises during that phase, even if the flag later becomes 1.
- R9: On every edge at which `phase_chg` is sampled low, `gate_o` becomes 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_chg | input | 1 | Charging-phase level, synchronous to clk (high = charge) |
| cmp_below_async | input | 1 | Asynchronous comparator flag, 1 = output below reference |
| start_hold | input | 1 | Startup flag; control begins after its high-to-low transition |
| tap_mid | input | CNT_W | Tick offset at which the middle leg may join |
| tap_late | input | CNT_W | Tick offset at which the largest leg may join |
| gate_o | output | 3 | Registered gate commands, bit 0 smallest leg, bit 2 largest |

## Verification
Several properties are checked on every cycle: the fixed leg order, the gates clearing whenever the phase is low, the idle state before startup, and the rule that each leg rises only at its own tick point with the output low. The exact number of cycles each leg conducts depends on the synchronizer latency and on where the crossing falls relative to the two offsets, so only the bench's phase scenarios can show it. The same holds for skipped phases and for the gates staying open through comparator chatter. The bench compares per-leg on-cycle counts against values derived from the tick offsets and crossing times.

// File: rtl/seq_leg_pkg.sv
package seq_leg_pkg;
  localparam int unsigned NUM_LEGS = 3;
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [NUM_LEGS-1:0] leg_vec_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o,
  output logic sync_prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign sync_o      = chain_q[STAGES-1];
  assign sync_prev_o = prev_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import seq_leg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_i,
  input  logic [CNT_W-1:0] tap_mid_i,
  input  logic [CNT_W-1:0] tap_late_i,
  output leg_vec_t         tap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             phase_q;
  logic [CNT_W-1:0] tick_q;
  logic             rise;

  assign rise = phase_i & ~phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      tick_q  <= '0;
    end else begin
      phase_q <= phase_i;
      if (rise)                            tick_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (phase_i && tick_q != CNT_MAX) tick_q <= tick_q + 1'b1;
    end
  end

  always_comb begin
    tap_o    = '0;
    tap_o[0] = rise;
    tap_o[1] = phase_i & ~rise & (tick_q == tap_mid_i);
    tap_o[2] = phase_i & ~rise & (tick_q == tap_late_i);
  end
endmodule

// File: rtl/leg_sequencer.sv
module leg_sequencer
  import seq_leg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     armed_i,
  input  logic     phase_i,
  input  logic     below_i,
  input  logic     below_prev_i,
  input  leg_vec_t tap_i,
  output leg_vec_t gate_o
);
  leg_vec_t gate_q;
  leg_vec_t join_mask;
  logic     hold_q;
  logic     crossed;

  assign crossed = below_prev_i & ~below_i;

  assign join_mask[0] = 1'b0;
  generate
    for (genvar k = 1; k < NUM_LEGS; k++) begin : g_join
      assign join_mask[k] = tap_i[k] & below_i & gate_q[k-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !armed_i) begin
      gate_q <= '0;
      hold_q <= 1'b0;
    end else if (!phase_i) begin
      gate_q <= '0;
      hold_q <= 1'b0;
    end else if (tap_i[0]) begin
      gate_q <= {{(NUM_LEGS-1){1'b0}}, below_i};
      hold_q <= ~below_i;
    end else if (hold_q || crossed) begin
      gate_q <= '0;
      hold_q <= 1'b1;
    end else begin
      gate_q <= gate_q | join_mask;
    end
  end

  assign gate_o = gate_q;

  // R5
  leg_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate_q[2] || gate_q[1]) && (!gate_q[1] || gate_q[0]));

  // R9
  ph2_off_chk: assert property (@(posedge clk) disable iff (rst)
    !phase_i |=> gate_q == '0);

  // R3 R7
  leg1_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q[0]) |-> $past(tap_i[0] && below_i));

  // R4
  leg2_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q[1]) |-> $past(tap_i[1] && below_i));

  // R4
  leg3_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q[2]) |-> $past(tap_i[2] && below_i));

  // R6
  cross_off_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_i && phase_i && !tap_i[0] && crossed) |=> gate_q == '0);
endmodule

// File: rtl/seq_leg_ctrl.sv
module seq_leg_ctrl
  import seq_leg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_chg,
  input  logic             cmp_below_async,
  input  logic             start_hold,
  input  logic [CNT_W-1:0] tap_mid,
  input  logic [CNT_W-1:0] tap_late,
  output logic [2:0]       gate_o
);
  logic     start_q;
  logic     armed_q;
  logic     below_s;
  logic     below_prev;
  leg_vec_t taps;
  leg_vec_t gates;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      start_q <= start_hold;
      if (start_q && !start_hold) armed_q <= 1'b1;
    end
  end

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .async_i     (cmp_below_async),
    .sync_o      (below_s),
    .sync_prev_o (below_prev)
  );

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .phase_i    (phase_chg),
    .tap_mid_i  (tap_mid),
    .tap_late_i (tap_late),
    .tap_o      (taps)
  );

  leg_sequencer u_seq (
    .clk          (clk),
    .rst          (rst),
    .armed_i      (armed_q),
    .phase_i      (phase_chg),
    .below_i      (below_s),
    .below_prev_i (below_prev),
    .tap_i        (taps),
    .gate_o       (gates)
  );

  assign gate_o = gates;

  // R2
  idle_before_start_chk: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> gate_o == 3'b000);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> gate_o == 3'b000);
endmodule

// File: tb/seq_leg_ctrl_tb.sv
module seq_leg_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = 8;
  localparam int PLEN  = 20;
  localparam int TMID  = 5;
  localparam int TLATE = 12;
  localparam int NVEC  = 7;
  localparam int NEVER = 99;

  // crossing tick, below at start, chatter after crossing
  localparam int VC[NVEC]   = '{NEVER, 6, 6, NEVER, 2, 11, 4};
  localparam int VB[NVEC]   = '{1,     1, 1, 0,     1, 1,  1};
  localparam int VCH[NVEC]  = '{0,     0, 1, 0,     0, 0,  1};

  logic             clk = 1'b0;
  logic             rst;
  logic             phase_chg;
  logic             cmp_below_async;
  logic             start_hold;
  logic [CNT_W-1:0] tap_mid;
  logic [CNT_W-1:0] tap_late;
  logic [2:0]       gate_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  seq_leg_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk             (clk),
    .rst             (rst),
    .phase_chg       (phase_chg),
    .cmp_below_async (cmp_below_async),
    .start_hold      (start_hold),
    .tap_mid         (tap_mid),
    .tap_late        (tap_late),
    .gate_o          (gate_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_on(input int c, input int t);
    int stop;
    stop = (c == NEVER) ? PLEN : ((c + 2 < PLEN) ? c + 2 : PLEN);
    return (stop > t) ? stop - t : 0;
  endfunction

  task automatic run_phase(input int c, input bit below0, input bit chat,
                           input bit live, input string tag);
    int n0 = 0, n1 = 0, n2 = 0, ph2bad = 0;
    @(negedge clk);
    phase_chg = 1'b0;
    cmp_below_async = below0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      if (gate_o != 3'b000) ph2bad++;
    end
    @(negedge clk);
    phase_chg = 1'b1;
    for (int j = 0; j < PLEN + 3; j++) begin
      @(posedge clk); #1;
      n0 += int'(gate_o[0]);
      n1 += int'(gate_o[1]);
      n2 += int'(gate_o[2]);
      @(negedge clk);
      if (below0 && j == c - 1) cmp_below_async = 1'b0;
      if (!below0 && j == 2)   cmp_below_async = 1'b1;
      if (chat && j >= c + 3 && j < PLEN - 1) cmp_below_async = ~cmp_below_async;
      if (j == PLEN - 1) phase_chg = 1'b0;
    end
    // R9: gates low through the non-charging stretch
    chk({tag, " R9 ph2"}, ph2bad, 0);
    if (!live || !below0) begin
      // R8 (skip) or R2 (not armed): no pulses at all
      chk({tag, " R8/R2 leg1"}, n0, 0);
      chk({tag, " R8/R2 leg2"}, n1, 0);
      chk({tag, " R8/R2 leg3"}, n2, 0);
    end else begin
      // R3 R4 R6 R7 per-leg on-cycle counts
      chk({tag, " R3 R6 leg1"}, n0, expect_on(c, 0));
      chk({tag, " R4 R7 leg2"}, n1, expect_on(c, TMID));
      chk({tag, " R4 R7 leg3"}, n2, expect_on(c, TLATE));
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    phase_chg = 1'b0;
    cmp_below_async = 1'b0;
    start_hold = 1'b0;
    tap_mid = CNT_W'(TMID);
    tap_late = CNT_W'(TLATE);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", int'(gate_o), 0);
    rst = 1'b0;
    start_hold = 1'b1;

    // R2: before startup falls, a needy phase produces nothing
    run_phase(NEVER, 1'b1, 1'b0, 1'b0, "prestart");
    @(negedge clk);
    start_hold = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      run_phase(VC[v], VB[v] != 0, VCH[v] != 0, 1'b1, $sformatf("vec%0d", v));
    end

    // R1 R2: reset in mid-phase clears gates and disarms
    @(negedge clk);
    phase_chg = 1'b0;
    cmp_below_async = 1'b1;
    repeat (4) @(negedge clk);
    phase_chg = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 leg1 on before reset", int'(gate_o), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-phase reset", int'(gate_o), 0);
    rst = 1'b0;
    phase_chg = 1'b0;
    repeat (3) @(negedge clk);
    phase_chg = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 disarmed after reset", int'(gate_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule